// File: doc/BRIEF.md
# Lane-Selected Vector Carry-Less Multiplier

This block performs up to four 64x64-bit carry-less multiplications at once. Carry-less means multiplication of polynomials over GF(2): partial products are combined with XOR and no carries propagate. Two wide source operands of up to 512 bits are split into 128-bit lanes. In every active lane, one 64-bit half of the first source is multiplied by one 64-bit half of the second source. The 128-bit product goes to the same lane of the destination.

A two-bit width selector sets how many lanes are active: one lane for 128-bit operands, two for 256 and four for 512. Two bits of an 8-bit selector byte choose, for all lanes together, which half of each lane feeds the multiplier from each source. The other six bits of that byte have no effect.

Results leave through a valid/ready handshake. With the default parameter setting, a single output register sits between the multipliers and the port. That register gives a fixed latency of one cycle and accepts a new operation every cycle. Field reduction, result masking and merging into a register file are done outside this block.

Top module: `vclmul_top`

## Requirements
- R1: The width selector `width_sel` sets the number of active lanes: 2'b00 gives 1 lane (128-bit operands), 2'b01 gives 2 lanes (256-bit) and 2'b10 or 2'b11 gives 4 lanes (512-bit).
- R2: In active lane i, the first-source qword used is `src_a[64*(2i+sel[0]) +: 64]`. Bit 0 of `sel` therefore picks the low (0) or high (1) half of the lane.
- R3: In active lane i, the second-source qword used is `src_b[64*(2i+sel[4]) +: 64]`. Bit 4 of `sel` therefore picks the low (0) or high (1) half of the lane.
- R4: Active lane i drives `dst[128*i +: 128]` with the carry-less (XOR-accumulated) product of its two selected qwords.
- R5: With `width_sel`=2'b00, `dst[127:0]` equals the single 64x64 carry-less product of the qwords chosen from `src_a[127:0]` and `src_b[127:0]`. Source bits above 127 have no effect.
- R6: Bits 1, 2, 3, 5, 6 and 7 of `sel` do not affect `dst`.
- R7: Destination lanes at or above the active lane count are driven to zero.
- R8: Bit 127 of every lane of `dst` is zero whenever `out_valid` is high.
- R9: When the pipeline option is on, an operation accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge. When `out_ready` is held high, an operation is accepted at every edge.
- R10: While `out_valid` is high and `out_ready` is low, `dst` and `out_valid` hold their values and `in_ready` is low. After reset, `out_valid` is 0 and `dst` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| width_sel | input | 2 | Operand width / lane count selector |
| sel | input | 8 | Half-select byte; bit 0 for src_a, bit 4 for src_b |
| src_a | input | 512 | First source operand |
| src_b | input | 512 | Second source operand |
| out_valid | output | 1 | Result present on dst |
| out_ready | input | 1 | Consumer takes the result |
| dst | output | 512 | Lane products |

## Verification
A wrong half selection or a swapped lane corrupts a whole 128-bit lane of `dst`. That error is visible on the output one cycle after the operation is accepted, and it differs by select combination. For that reason each of the four select pairs is driven with operands whose halves all differ. A wrong lane count shows up as non-zero upper lanes, or as missing products, in the same cycle as the result. A fault in the output register or in the handshake shows as a result that changes or is lost while the consumer stalls, or as a gap in back-to-back results.

// File: rtl/vclmul_pkg.sv
package vclmul_pkg;
  localparam int unsigned QW_BITS  = 64;
  localparam int unsigned MAX_LANE = 4;

  localparam logic [1:0] WSEL_128 = 2'b00;
  localparam logic [1:0] WSEL_256 = 2'b01;
  localparam logic [1:0] WSEL_512 = 2'b10;

  // lanes enabled by the width selector, clipped to the built lane count
  function automatic int unsigned lanes_on(input logic [1:0] ws, input int unsigned built);
    int unsigned n;
    n = ws[1] ? 4 : (ws[0] ? 2 : 1);
    return (n > built) ? built : n;
  endfunction
endpackage

// File: rtl/clmul_core.sv
module clmul_core #(
  parameter int unsigned QW = 64
) (
  input  logic [QW-1:0]   op_x,
  input  logic [QW-1:0]   op_y,
  output logic [2*QW-1:0] prod
);
  localparam int unsigned PW = 2*QW;

  logic [PW-1:0] part [QW];

  genvar k;
  generate
    for (k = 0; k < QW; k++) begin : g_pp
      assign part[k] = op_y[k] ? ({{QW{1'b0}}, op_x} << k) : '0;
    end
  endgenerate

  always_comb begin
    prod = '0;
    for (int j = 0; j < QW; j++) prod = prod ^ part[j];
  end
endmodule

// File: rtl/lane_pick.sv
module lane_pick #(
  parameter int unsigned QW    = 64,
  parameter int unsigned LANES = 4
) (
  input  logic [2*QW*LANES-1:0] src,
  input  logic                  hi,
  output logic [QW*LANES-1:0]   picked
);
  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      assign picked[QW*i +: QW] = hi ? src[QW*(2*i+1) +: QW] : src[QW*(2*i) +: QW];
    end
  endgenerate
endmodule

// File: rtl/vclmul_stage.sv
module vclmul_stage #(
  parameter int unsigned W    = 512,
  parameter bit          PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (PIPE) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;
      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end

      assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
      assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/vclmul_top.sv
module vclmul_top #(
  parameter int unsigned QW    = vclmul_pkg::QW_BITS,
  parameter int unsigned LANES = vclmul_pkg::MAX_LANE,
  parameter bit          PIPE  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            width_sel,
  input  logic [7:0]            sel,
  input  logic [2*QW*LANES-1:0] src_a,
  input  logic [2*QW*LANES-1:0] src_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*QW*LANES-1:0] dst
);
  import vclmul_pkg::*;

  localparam int unsigned LW = 2*QW;
  localparam int unsigned DW = LW*LANES;

  logic [QW*LANES-1:0] qa, qb;
  logic [DW-1:0]       raw, masked;
  logic [LANES-1:0]    act;

  lane_pick #(.QW(QW), .LANES(LANES)) u_pick_a (.src(src_a), .hi(sel[0]), .picked(qa));
  lane_pick #(.QW(QW), .LANES(LANES)) u_pick_b (.src(src_b), .hi(sel[4]), .picked(qb));

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_mul
      clmul_core #(.QW(QW)) u_core (
        .op_x (qa[QW*g +: QW]),
        .op_y (qb[QW*g +: QW]),
        .prod (raw[LW*g +: LW])
      );
      assign act[g] = (g < lanes_on(width_sel, LANES));
      assign masked[LW*g +: LW] = act[g] ? raw[LW*g +: LW] : '0;

      assert_msb_zero_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !dst[LW*g + LW - 1]);
    end
  endgenerate

  vclmul_stage #(.W(DW), .PIPE(PIPE)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (masked),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (dst)
  );

  // lane 0 is active in every mode and the enabled lanes form a contiguous run from lane 0
  always_comb begin
    assert_lanes_R1: assert (act[0] && (((act + 1'b1) & act) == '0));
  end

  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && dst == '0));
endmodule

// File: tb/tb_vclmul_top.sv
module tb_vclmul_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   width_sel = 2'b00;
  logic [7:0]   sel = 8'h00;
  logic [511:0] src_a = '0;
  logic [511:0] src_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [511:0] dst;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vclmul_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .width_sel(width_sel), .sel(sel), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .dst(dst)
  );

  // shift-and-XOR reference, Horner order over the multiplier bits
  function automatic logic [127:0] ref_mul(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      r = r << 1;
      if (y[i]) r = r ^ {64'b0, x};
    end
    return r;
  endfunction

  function automatic logic [511:0] expect_dst(input logic [1:0] ws, input logic [7:0] s,
                                               input logic [511:0] a, input logic [511:0] b);
    logic [511:0] e;
    int n;
    e = '0;
    n = ws[1] ? 4 : (ws[0] ? 2 : 1);
    for (int i = 0; i < n; i++)
      e[128*i +: 128] = ref_mul(a[64*(2*i + s[0]) +: 64], b[64*(2*i + s[4]) +: 64]);
    return e;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation with out_ready high; result checked at the following negedge
  task automatic run_one(input logic [1:0] ws, input logic [7:0] s,
                         input logic [511:0] a, input logic [511:0] b, input string tag);
    logic [511:0] e;
    e = expect_dst(ws, s, a, b);
    @(negedge clk);
    width_sel = ws; sel = s; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " valid"}, {511'b0, out_valid}, 512'd1);
    chk(dst === e, tag, dst, e);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R10 reset valid", {511'b0, out_valid}, 512'd0);
    chk(dst === '0, "R10 reset dst", dst, '0);
  endtask

  task automatic t_classic();
    for (int k = 0; k < 4; k++)
      run_one(2'b00, {3'b0, k[1], 3'b0, k[0]}, rnd512(), rnd512(), "R5 R1 single lane");
    run_one(2'b00, 8'h11, {384'hFFFF, 128'h8000_0000_0000_0000_0000_0000_0000_0001},
            {384'h1234, 128'h8000_0000_0000_0001_0000_0000_0000_0003}, "R5 high-bit operands");
  endtask

  task automatic t_selectors();
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 3; r++)
        run_one(2'b10, {3'b0, k[1], 3'b0, k[0]}, rnd512(), rnd512(), "R2 R3 R4 select pair");
  endtask

  task automatic t_modes();
    logic [511:0] a, b;
    a = rnd512(); b = rnd512();
    run_one(2'b01, 8'h10, a, b, "R1 R7 two lanes");
    run_one(2'b11, 8'h01, a, b, "R1 four lanes code 11");
    run_one(2'b00, 8'h00, a, b, "R7 upper lanes zero");
  endtask

  task automatic t_ignore();
    logic [511:0] a, b;
    a = rnd512(); b = rnd512();
    run_one(2'b10, 8'hEE, a, b, "R6 unused bits set, both low");
    run_one(2'b10, 8'hFF, a, b, "R6 unused bits set, both high");
    run_one(2'b10, 8'h6C, a, b, "R6 unused bits mixed");
  endtask

  task automatic t_msb();
    run_one(2'b10, 8'h00, {512{1'b1}}, {512{1'b1}}, "R8 all-ones");
    chk(dst[127] == 1'b0 && dst[255] == 1'b0 && dst[383] == 1'b0 && dst[511] == 1'b0,
        "R8 lane top bits", dst, '0);
  endtask

  task automatic t_b2b();
    logic [511:0] ea [6];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk(out_valid == 1'b1 && in_ready == 1'b1, "R9 b2b valid", {511'b0, out_valid}, 512'd1);
        chk(dst === ea[k-1], "R9 b2b data", dst, ea[k-1]);
      end
      width_sel = 2'(k % 3); sel = 8'(k * 8'h13); src_a = rnd512(); src_b = rnd512();
      ea[k] = expect_dst(width_sel, sel, src_a, src_b);
      in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(dst === ea[5], "R9 b2b last", dst, ea[5]);
  endtask

  task automatic t_backpressure();
    logic [511:0] e1, e2;
    @(negedge clk);
    out_ready = 1'b0;
    width_sel = 2'b10; sel = 8'h10; src_a = rnd512(); src_b = rnd512();
    e1 = expect_dst(width_sel, sel, src_a, src_b);
    in_valid = 1'b1;
    @(negedge clk);
    sel = 8'h01; src_a = rnd512(); src_b = rnd512();
    e2 = expect_dst(width_sel, sel, src_a, src_b);
    for (int c = 0; c < 3; c++) begin
      chk(out_valid == 1'b1 && in_ready == 1'b0, "R10 stall flags", {511'b0, in_ready}, '0);
      chk(dst === e1, "R10 stall hold", dst, e1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && dst === e2, "R10 resume next", dst, e2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 drained", {511'b0, out_valid}, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_classic();
    t_selectors();
    t_modes();
    t_ignore();
    t_msb();
    t_b2b();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule